// File: doc/BRIEF.md
# Multichannel ADC Scan Result Buffer

This block controls one conversion scan of a serial-bus ADC front end and stores the results in a small RAM. A read command starts the scan. The block then asks an external converter for one conversion per selected channel, one channel at a time, and writes each 8-bit result to the next RAM location. For the whole scan it asserts a bus stretch request, which holds the bus clock low. The request drops only after the last result has been stored.

When the scan is done, the bus side fetches bytes one at a time. They come back in the order they were converted. After the last valid result the read pointer returns to the first result, so reading never runs out. The stored results do not change until a new read command starts a fresh scan.

Control bytes set the scan. A byte with bit 7 set is a setup byte: its bit 1 turns the shared input pin into a reference, and that channel is then left out of multichannel scans. A byte with bit 7 clear is a configuration byte: its bits [6:5] select the scan mode and its low CH_W bits give the highest channel. The state machine has four states:
- IDLE: the state after reset.
- REQ: a conversion request for the current channel is issued.
- WAIT: the block waits for the converter to report done.
- READY: results can be read.

Its transitions are:
- IDLE→REQ on a read start.
- REQ→WAIT always.
- WAIT→REQ on done when more channels remain.
- WAIT→READY on done for the last channel.
- READY→REQ on a read start, which begins a new scan.

Top module: `scan_result_buffer`

## Requirements
- R1: After reset, stretch, conv_req and res_ready are 0 and byte_out is 0. The configuration after reset is sweep mode, highest channel 0, reference off.
- R2: A rd_start in IDLE or READY starts a scan. stretch is 1 from the next cycle. Each conversion is requested by a one-cycle conv_req pulse. The request for the next channel follows the conv_done of the previous one.
- R3: stretch stays 1 until the conv_done of the last channel. In the cycle after that conv_done, stretch is 0 and res_ready is 1.
- R4: With configuration mode bits [6:5] not equal to 01, the scan converts channels 0 up to the highest channel, in ascending order. A highest-channel field above NUM_CH-1 is treated as NUM_CH-1.
- R5: With mode bits [6:5] equal to 01, the scan converts only the highest channel (after clamping). This holds even when that channel is the reference channel.
- R6: Results are stored in successive locations. Each byte_req in READY returns the next result on byte_out one cycle later, starting with the first conversion of the scan.
- R7: After the last valid result of the scan, the next read returns the first result. The wrap point is the number of results in the scan, not the RAM depth.
- R8: A setup byte (bit 7 = 1) sets the reference enable from its bit 1. While the reference is enabled, channel NUM_CH-1 is skipped in sweep mode.
- R9: The configuration is captured when a scan starts. Control bytes written during a scan affect only the next scan.
- R10: A rd_start during a scan is ignored. It neither restarts the scan nor adds conversions.
- R11: A byte_req outside READY leaves byte_out unchanged. Results stay frozen until a new rd_start. After a new scan, reading starts again at its first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte strobe |
| ctl_byte | input | 8 | Setup byte (bit 7 = 1) or configuration byte (bit 7 = 0) |
| rd_start | input | 1 | Read command pulse; starts a scan |
| byte_req | input | 1 | Request the next result byte |
| byte_out | output | DATA_W | Result byte, valid the cycle after byte_req |
| res_ready | output | 1 | Results available for reading |
| stretch | output | 1 | Bus clock stretch request, high during a scan |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | CH_W | Channel to convert |
| conv_done | input | 1 | Converter finished; conv_data valid |
| conv_data | input | DATA_W | Conversion result |

## Verification
The bench sweeps every highest-channel value, including values past the last channel, with the reference both off and on, in both scan modes. Each scan is compared with an expected channel list worked out in the bench, and each scan is read one byte past its end.

Faults the bench is built to catch:
- A design that skipped the reference channel in single mode would convert nothing or the wrong channel.
- A design that wrapped at the RAM depth would return stale bytes after the last valid result.
- Restarting on a mid-scan read command would log extra conversions.
- Capturing the configuration late would scan with the new channel limit.
- Dropping stretch early would release the bus while a conversion is still pending.

// File: rtl/scanbuf_pkg.sv
package scanbuf_pkg;
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_READY} scan_state_t;
    localparam logic [1:0] MODE_SINGLE = 2'b01;
endpackage

// File: rtl/scan_chan_step.sv
module scan_chan_step #(
    parameter int NUM_CH = 12,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [CH_W-1:0] cur,
    input  logic            ref_skip,
    input  logic [CH_W-1:0] top,
    output logic [CH_W-1:0] nxt,
    output logic            last
);
    localparam logic [CH_W:0] REF_IDX = (CH_W+1)'(NUM_CH - 1);

    logic [CH_W:0] inc;

    always_comb begin
        inc = {1'b0, cur} + 1'b1;
        if (ref_skip && inc == REF_IDX) begin
            inc = inc + 1'b1;
        end
        last = (inc > {1'b0, top});
        nxt  = inc[CH_W-1:0];
    end
endmodule

// File: rtl/scan_result_store.sv
module scan_result_store #(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 8,
    parameter int PTR_W  = $clog2(NUM_CH),
    parameter int CNT_W  = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              seal,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NUM_CH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              at_end;

    assign at_end = (rd_ptr == PTR_W'(count - 1'b1));

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            if (wr_clr) begin
                wr_ptr <= '0;
            end else if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (seal) begin
                count  <= CNT_W'(wr_ptr) + 1'b1;
                rd_ptr <= '0;
            end else if (rd_en) begin
                rd_data <= mem[rd_ptr];
                rd_ptr  <= at_end ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    // R6: a write never lands past the last RAM entry
    p_wr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_ptr) < NUM_CH));

    // R7: reading the last valid result sends the pointer back to the first
    p_wrap_to_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !seal && at_end) |=> (rd_ptr == '0));
endmodule

// File: rtl/scan_result_buffer.sv
module scan_result_buffer
    import scanbuf_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int DATA_W = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_byte,
    input  logic              rd_start,
    input  logic              byte_req,
    output logic [DATA_W-1:0] byte_out,
    output logic              res_ready,
    output logic              stretch,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    scan_state_t     st, st_nx;
    logic            ref_en_r;
    logic [1:0]      mode_r;
    logic [CH_W-1:0] top_r, top_clamp;
    logic [CH_W-1:0] ch, scan_top, step_nxt;
    logic            scan_ref, scan_single, step_last, scan_end;
    logic            start, wr_en, seal, rd_en;

    // control byte decode: bit 7 picks setup or configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_en_r <= 1'b0;
            mode_r   <= 2'b00;
            top_r    <= '0;
        end else if (ctl_wr) begin
            if (ctl_byte[7]) begin
                ref_en_r <= ctl_byte[1];
            end else begin
                mode_r <= ctl_byte[6:5];
                top_r  <= ctl_byte[CH_W-1:0];
            end
        end
    end

    assign top_clamp = (top_r > LAST_CH) ? LAST_CH : top_r;
    assign start     = rd_start && (st == S_IDLE || st == S_READY);
    assign scan_end  = scan_single || step_last;
    assign wr_en     = (st == S_WAIT) && conv_done;
    assign seal      = wr_en && scan_end;
    assign rd_en     = byte_req && (st == S_READY) && !rd_start;

    scan_chan_step #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_step (
        .cur      (ch),
        .ref_skip (scan_ref),
        .top      (scan_top),
        .nxt      (step_nxt),
        .last     (step_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (rd_start)  st_nx = S_REQ;
            S_REQ:                  st_nx = S_WAIT;
            S_WAIT:  if (conv_done) st_nx = scan_end ? S_READY : S_REQ;
            S_READY: if (rd_start)  st_nx = S_REQ;
            default:                st_nx = S_IDLE;
        endcase
    end

    // scan channel and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch          <= '0;
            scan_top    <= '0;
            scan_ref    <= 1'b0;
            scan_single <= 1'b0;
        end else if (start) begin
            ch          <= (mode_r == MODE_SINGLE) ? top_clamp : '0;
            scan_top    <= top_clamp;
            scan_ref    <= ref_en_r;
            scan_single <= (mode_r == MODE_SINGLE);
        end else if (wr_en && !scan_end) begin
            ch <= step_nxt;
        end
    end

    // outputs
    always_comb begin
        conv_req  = (st == S_REQ);
        stretch   = (st == S_REQ) || (st == S_WAIT);
        res_ready = (st == S_READY);
        conv_ch   = ch;
    end

    scan_result_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_clr  (start),
        .wr_en   (wr_en),
        .wr_data (conv_data),
        .seal    (seal),
        .rd_en   (rd_en),
        .rd_data (byte_out)
    );

    // R3: stretch only falls right after a conversion finished
    p_stretch_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stretch) |-> $past(conv_done));

    // R2: each conversion request lasts exactly one cycle
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R8: reference channel never requested in a sweep with reference on
    p_ref_skipped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && scan_ref && !scan_single) |-> (conv_ch != LAST_CH));

    // R4: never converts past the captured highest channel
    p_ch_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_ch <= scan_top));

    // R10: a pending conversion is not abandoned by a read start
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && !conv_done) |=> (st == S_WAIT));
endmodule

// File: tb/scan_result_buffer_test.sv
module scan_result_buffer_test;
    localparam int NUM_CH = 12;
    localparam int DATA_W = 8;
    localparam int CH_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_wr = 1'b0;
    logic [7:0]        ctl_byte = '0;
    logic              rd_start = 1'b0;
    logic              byte_req = 1'b0;
    logic [DATA_W-1:0] byte_out;
    logic              res_ready, stretch, conv_req;
    logic [CH_W-1:0]   conv_ch;
    logic              conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    scan_result_buffer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
        .rd_start(rd_start), .byte_req(byte_req), .byte_out(byte_out),
        .res_ready(res_ready), .stretch(stretch), .conv_req(conv_req),
        .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data)
    );

    // converter model and conversion log
    int       scan_id = 0;
    int       log_ch [64];
    int       log_n = 0;
    bit       busy = 0;
    int       lat = 0;
    int       cur_ch = 0;

    always @(negedge clk) begin
        conv_done = 1'b0;
        if (busy) begin
            if (lat == 0) begin
                conv_done = 1'b1;
                conv_data = {4'(scan_id), 4'(cur_ch)};
                busy = 0;
            end else begin
                lat--;
            end
        end
        if (conv_req) begin
            busy = 1;
            cur_ch = int'(conv_ch);
            lat = cur_ch % 3;
            if (log_n < 64) log_ch[log_n] = cur_ch;
            log_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] b);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_byte = b;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] v);
        @(negedge clk);
        byte_req = 1'b1;
        @(negedge clk);
        byte_req = 1'b0;
        v = byte_out;
    endtask

    // expected channel list for a scan
    int exp_ch [16];
    int exp_n;

    task automatic build_exp(input int top, input bit single, input bit refen);
        int t = (top > NUM_CH - 1) ? NUM_CH - 1 : top;
        exp_n = 0;
        if (single) begin
            exp_ch[0] = t; exp_n = 1;
        end else begin
            for (int c = 0; c <= t; c++) begin
                if (!(refen && c == NUM_CH - 1)) begin
                    exp_ch[exp_n] = c; exp_n++;
                end
            end
        end
    endtask

    // start a scan, optionally disturbing it, wait for results, verify
    task automatic run_scan(input string tag, input bit disturb);
        bit stretch_ok = 1;
        int guard = 0;
        logic [7:0] v;
        scan_id++;
        log_n = 0;
        @(negedge clk);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        check(stretch === 1'b1, "R2", int'(stretch), 1);
        if (disturb) begin
            rd_start = 1'b1;          // R10: ignored mid-scan
            write_ctl(8'h01);         // R9: new config, next scan only
            rd_start = 1'b0;
        end
        while (!res_ready && guard < 500) begin
            if (!stretch) stretch_ok = 0;
            byte_req = 1'b1;          // R11: no effect during scan
            @(negedge clk);
            guard++;
        end
        byte_req = 1'b0;
        check(stretch_ok && !stretch && res_ready, {"R3 ", tag}, int'(stretch), 0);
        check(log_n == exp_n, {"R4/R5/R8/R10 count ", tag}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            check(log_ch[i] == exp_ch[i], {"R4/R5/R8 channel ", tag}, log_ch[i], exp_ch[i]);
        for (int i = 0; i <= exp_n; i++) begin
            int k = i % exp_n;
            int e = ((scan_id % 16) << 4) | exp_ch[k];
            read_byte(v);
            check(int'(v) == e, (i == exp_n) ? {"R7 wrap ", tag} : {"R6 order ", tag}, int'(v), e);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!stretch && !conv_req && !res_ready, "R1 outputs", int'(stretch), 0);
        check(byte_out == '0, "R1 byte_out", int'(byte_out), 0);
        // R11: byte_req in IDLE ignored
        read_byte(v);
        check(v == '0, "R11 idle byte_req", int'(v), 0);
        // R1: default config is sweep, top 0
        build_exp(0, 0, 0);
        run_scan("default", 0);

        // R4/R8 sweeps and R5 single, every top value
        for (int refen = 0; refen < 2; refen++) begin
            write_ctl(refen ? 8'h82 : 8'h80);
            for (int top = 0; top < 16; top++) begin
                write_ctl(8'(top));
                build_exp(top, 0, refen[0]);
                run_scan("sweep", 0);
                write_ctl(8'h20 | 8'(top));
                build_exp(top, 1, refen[0]);
                run_scan("single", 0);
            end
        end
        // R4: mode 10 and 11 act as sweep
        write_ctl(8'h80);
        write_ctl(8'h45);
        build_exp(5, 0, 0);
        run_scan("mode10", 0);
        write_ctl(8'h67);
        build_exp(7, 0, 0);
        run_scan("mode11", 0);

        // R9/R10: disturbed scan uses old config, next scan new one
        write_ctl(8'h0B);
        build_exp(11, 0, 0);
        run_scan("disturbed", 1);
        build_exp(1, 0, 0);
        run_scan("after disturb R9", 0);

        // R11: frozen results, byte_req keeps going, then new scan
        repeat (20) @(negedge clk);
        read_byte(held);
        check(int'(held) == (((scan_id % 16) << 4) | 1), "R11 frozen", int'(held),
              ((scan_id % 16) << 4) | 1);
        write_ctl(8'h03);
        build_exp(3, 0, 0);
        run_scan("restart R11", 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule